// File: doc/BRIEF.md
# Data Pointer and Table-Read Unit

This unit holds the accumulator and the two data-memory pointer registers of a small 8-bit core, B and X, and carries out the operand moves that use them. A command names an operation, a pointer, and a post-access step. Loads and stores through a pointer, and the exchange of the accumulator with a memory byte, drive a data-memory address from the chosen pointer. After the access, that pointer may be incremented or decremented, wrapping modulo 256. The unit can also load B with a 4-bit short immediate, which clears B's upper nibble. It can also load A or X with a full byte.

A table read fetches a constant from program memory. For the duration of the access, the accumulator stands in for the low byte of the program counter. The program-memory address is therefore the upper program-counter bits joined with A. The exchanged low byte is also visible on `pcl_o`. When the byte returns, it is written into A and the program-counter low byte reads its own value again. Both memories answer through a request/valid handshake. While any multi-cycle sequence runs, `busy_o` is high and new commands are ignored.

Top module: `dptr_tbl_unit`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after its release, `acc_o`, `b_o` and `x_o` are 00 hex, and `busy_o`, `dmem_req_o` and `pmem_req_o` are 0.
- R2: Commands are accepted only when `busy_o` is 0. Op 1 loads `cmd_imm_i` into A, and op 3 loads `cmd_imm_i` into X. Each takes effect on the accepting edge, and `busy_o` stays 0.
- R3: Op 2, the short load of B, sets B to `{4'b0000, cmd_imm_i[3:0]}` on the accepting edge. The upper four bits of `cmd_imm_i` have no effect.
- R4: Op 4 (indirect load) raises `dmem_req_o` with `dmem_we_o`=0 in the cycle after acceptance. The address is the pointer chosen by `cmd_sel_i` (0 = B, 1 = X). Request and address hold until a cycle with `dmem_rvalid_i`=1, and `dmem_rdata_i` from that cycle is written into A.
- R5: `cmd_step_i` selects what happens to the chosen pointer when the access ends: 0 or 3 leaves it unchanged, 1 adds one, and 2 subtracts one, all modulo 256. The address driven during the access is the value before the step.
- R6: Op 5 (indirect store) drives exactly one cycle with `dmem_req_o`=1 and `dmem_we_o`=1, with address = pointer and data = A, in the cycle after acceptance.
- R7: Op 6 (exchange) first reads the pointed byte as in R4, writing it into A. In the next cycle it writes the former A back to the same address for one cycle, and then applies the step.
- R8: Op 7 (table read) raises `pmem_req_o` for exactly one cycle, the cycle after acceptance. The address is `{pc_i[14:8], A}`. From that cycle until the returned byte is taken, `pcl_o` shows A.
- R9: The first `pmem_rvalid_i` after the request cycle delivers the byte. One cycle later, A holds that byte and `busy_o` falls. From the cycle after the byte is taken, `pcl_o` equals `pc_i[7:0]` again.
- R10: While `busy_o` is 1, a command held on `cmd_valid_i` is ignored. Neither memory request is raised while `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_op_i | input | 3 | Operation code (R2 to R8) |
| cmd_sel_i | input | 1 | Pointer select: 0 = B, 1 = X |
| cmd_step_i | input | 2 | Post-access step: 0/3 none, 1 increment, 2 decrement |
| cmd_imm_i | input | 8 | Immediate operand |
| pc_i | input | 15 | Current program counter |
| busy_o | output | 1 | Multi-cycle sequence in progress |
| acc_o | output | 8 | Accumulator |
| b_o | output | 8 | Pointer B |
| x_o | output | 8 | Pointer X |
| pcl_o | output | 8 | Effective program-counter low byte |
| dmem_req_o | output | 1 | Data-memory request |
| dmem_we_o | output | 1 | Data-memory write enable |
| dmem_addr_o | output | 8 | Data-memory address |
| dmem_wdata_o | output | 8 | Data-memory write data |
| dmem_rvalid_i | input | 1 | Data-memory read data valid |
| dmem_rdata_i | input | 8 | Data-memory read data |
| pmem_req_o | output | 1 | Program-memory read request |
| pmem_addr_o | output | 15 | Program-memory address |
| pmem_rvalid_i | input | 1 | Program-memory read data valid |
| pmem_rdata_i | input | 8 | Program-memory read data |

## Verification
Two functions can coincide in one cycle: the final cycle of a pointer access, where the step and the read or write-back complete, and a new command offered at that moment. The bench keeps a full-byte load of A asserted on the command inputs throughout exchanges. It then checks that A ends with the memory byte and not the immediate, and that the write address was the pointer value before the step. Sweeps cover both pointers, every step code, several read latencies, and pointer values at 00 and FF hex, so that wrap-around is checked. Every short-load immediate and a spread of accumulator values are also covered, the latter through table reads.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_LDA_IMM   = 3'd1,
    OP_LDB_SHORT = 3'd2,
    OP_LDX_IMM   = 3'd3,
    OP_LDA_IND   = 3'd4,
    OP_STA_IND   = 3'd5,
    OP_XCH_IND   = 3'd6,
    OP_TBL_RD    = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2,
    STEP_KEEP = 2'd3
  } step_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DRD   = 3'd1,
    ST_DWR   = 3'd2,
    ST_TISS  = 3'd3,
    ST_TWAIT = 3'd4,
    ST_TDONE = 3'd5
  } state_e;

  typedef enum logic [1:0] {
    ACC_SRC_IMM  = 2'd0,
    ACC_SRC_DMEM = 2'd1,
    ACC_SRC_TBL  = 2'd2
  } acc_src_e;

  typedef struct packed {
    op_e   op;
    logic  sel;
    step_e step;
  } cmd_t;

  localparam int unsigned NUM_PTR = 2;
endpackage

// File: rtl/dptr_step.sv
module dptr_step #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] ptr_i,
  input  logic [1:0]    step_i,
  output logic [DW-1:0] ptr_o
);
  import dptr_pkg::*;

  always_comb begin
    unique case (step_e'(step_i))
      STEP_INC: ptr_o = ptr_i + DW'(1);
      STEP_DEC: ptr_o = ptr_i - DW'(1);
      default:  ptr_o = ptr_i;
    endcase
  end
endmodule

// File: rtl/dptr_regs.sv
module dptr_regs #(
  parameter int unsigned DW = 8
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 acc_we_i,
  input  logic [DW-1:0]                        acc_d_i,
  input  logic [dptr_pkg::NUM_PTR-1:0]         ptr_ld_i,
  input  logic [DW-1:0]                        ptr_ld_d_i,
  input  logic                                 step_en_i,
  input  logic                                 step_sel_i,
  input  logic [1:0]                           step_i,
  output logic [DW-1:0]                        acc_o,
  output logic [dptr_pkg::NUM_PTR-1:0][DW-1:0] ptr_o
);
  import dptr_pkg::*;

  logic [DW-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (acc_we_i) acc_q <= acc_d_i;
  end

  assign acc_o = acc_q;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic [DW-1:0] ptr_q;
    logic [DW-1:0] ptr_nxt;

    dptr_step #(.DW(DW)) u_step (
      .ptr_i  (ptr_q),
      .step_i (step_i),
      .ptr_o  (ptr_nxt)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ptr_q <= '0;
      else if (ptr_ld_i[g])                         ptr_q <= ptr_ld_d_i;
      else if (step_en_i && (step_sel_i == 1'(g)))  ptr_q <= ptr_nxt;
    end

    assign ptr_o[g] = ptr_q;
  end
endmodule

// File: rtl/dptr_ctrl.sv
module dptr_ctrl (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cmd_valid_i,
  input  dptr_pkg::cmd_t               cmd_i,
  input  logic                         dmem_rvalid_i,
  input  logic                         pmem_rvalid_i,
  output dptr_pkg::state_e             state_o,
  output dptr_pkg::cmd_t               cur_o,
  output logic                         accept_o,
  output logic                         acc_we_o,
  output dptr_pkg::acc_src_e           acc_src_o,
  output logic [dptr_pkg::NUM_PTR-1:0] ptr_ld_o,
  output logic                         step_en_o,
  output logic                         tbuf_we_o
);
  import dptr_pkg::*;

  state_e state_q, state_d;
  cmd_t   cur_q;

  assign accept_o = cmd_valid_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_o) begin
          unique case (cmd_i.op)
            OP_LDA_IND, OP_XCH_IND: state_d = ST_DRD;
            OP_STA_IND:             state_d = ST_DWR;
            OP_TBL_RD:              state_d = ST_TISS;
            default:                state_d = ST_IDLE;
          endcase
        end
      end
      ST_DRD:   if (dmem_rvalid_i) state_d = (cur_q.op == OP_XCH_IND) ? ST_DWR : ST_IDLE;
      ST_DWR:   state_d = ST_IDLE;
      ST_TISS:  state_d = ST_TWAIT;
      ST_TWAIT: if (pmem_rvalid_i) state_d = ST_TDONE;
      ST_TDONE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o) cur_q <= cmd_i;
    end
  end

  always_comb begin
    acc_we_o  = 1'b0;
    acc_src_o = ACC_SRC_IMM;
    ptr_ld_o  = '0;
    step_en_o = 1'b0;
    tbuf_we_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_o) begin
          acc_we_o = (cmd_i.op == OP_LDA_IMM);
          ptr_ld_o[0] = (cmd_i.op == OP_LDB_SHORT);
          ptr_ld_o[1] = (cmd_i.op == OP_LDX_IMM);
        end
      end
      ST_DRD: begin
        if (dmem_rvalid_i) begin
          acc_we_o  = 1'b1;
          acc_src_o = ACC_SRC_DMEM;
          step_en_o = (cur_q.op == OP_LDA_IND);
        end
      end
      ST_DWR:   step_en_o = 1'b1;
      ST_TWAIT: tbuf_we_o = pmem_rvalid_i;
      ST_TDONE: begin
        acc_we_o  = 1'b1;
        acc_src_o = ACC_SRC_TBL;
      end
      default: ;
    endcase
  end

  assign state_o = state_q;
  assign cur_o   = cur_q;
endmodule

// File: rtl/dptr_tbl_unit.sv
module dptr_tbl_unit #(
  parameter int unsigned DW  = 8,
  parameter int unsigned PCW = 15
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  input  logic [2:0]     cmd_op_i,
  input  logic           cmd_sel_i,
  input  logic [1:0]     cmd_step_i,
  input  logic [DW-1:0]  cmd_imm_i,
  input  logic [PCW-1:0] pc_i,
  output logic           busy_o,
  output logic [DW-1:0]  acc_o,
  output logic [DW-1:0]  b_o,
  output logic [DW-1:0]  x_o,
  output logic [DW-1:0]  pcl_o,
  output logic           dmem_req_o,
  output logic           dmem_we_o,
  output logic [DW-1:0]  dmem_addr_o,
  output logic [DW-1:0]  dmem_wdata_o,
  input  logic           dmem_rvalid_i,
  input  logic [DW-1:0]  dmem_rdata_i,
  output logic           pmem_req_o,
  output logic [PCW-1:0] pmem_addr_o,
  input  logic           pmem_rvalid_i,
  input  logic [DW-1:0]  pmem_rdata_i
);
  import dptr_pkg::*;

  localparam int unsigned NIB = DW / 2;
  localparam int unsigned PGW = PCW - DW;

  cmd_t                        cmd;
  cmd_t                        cur;
  state_e                      state;
  acc_src_e                    acc_src;
  logic                        accept;
  logic                        acc_we;
  logic [NUM_PTR-1:0]          ptr_ld;
  logic                        step_en;
  logic                        tbuf_we;
  logic [DW-1:0]               acc_d;
  logic [DW-1:0]               ptr_ld_d;
  logic [DW-1:0]               acc;
  logic [NUM_PTR-1:0][DW-1:0]  ptr;
  logic [DW-1:0]               wbuf_q;
  logic [DW-1:0]               tbuf_q;
  logic                        tbl_swap;

  assign cmd.op   = op_e'(cmd_op_i);
  assign cmd.sel  = cmd_sel_i;
  assign cmd.step = step_e'(cmd_step_i);

  dptr_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_i         (cmd),
    .dmem_rvalid_i (dmem_rvalid_i),
    .pmem_rvalid_i (pmem_rvalid_i),
    .state_o       (state),
    .cur_o         (cur),
    .accept_o      (accept),
    .acc_we_o      (acc_we),
    .acc_src_o     (acc_src),
    .ptr_ld_o      (ptr_ld),
    .step_en_o     (step_en),
    .tbuf_we_o     (tbuf_we)
  );

  always_comb begin
    unique case (acc_src)
      ACC_SRC_DMEM: acc_d = dmem_rdata_i;
      ACC_SRC_TBL:  acc_d = tbuf_q;
      default:      acc_d = cmd_imm_i;
    endcase
  end

  // short load of B zeroes the upper half
  assign ptr_ld_d = ptr_ld[0] ? {{(DW-NIB){1'b0}}, cmd_imm_i[NIB-1:0]} : cmd_imm_i;

  dptr_regs #(.DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_we_i   (acc_we),
    .acc_d_i    (acc_d),
    .ptr_ld_i   (ptr_ld),
    .ptr_ld_d_i (ptr_ld_d),
    .step_en_i  (step_en),
    .step_sel_i (cur.sel),
    .step_i     (cur.step),
    .acc_o      (acc),
    .ptr_o      (ptr)
  );

  // wbuf keeps A as it was at acceptance; exchange overwrites A before writing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbuf_q <= '0;
      tbuf_q <= '0;
    end else begin
      if (accept && (cmd.op == OP_STA_IND || cmd.op == OP_XCH_IND)) wbuf_q <= acc;
      if (tbuf_we) tbuf_q <= pmem_rdata_i;
    end
  end

  assign tbl_swap = (state == ST_TISS) || (state == ST_TWAIT);

  assign busy_o       = (state != ST_IDLE);
  assign acc_o        = acc;
  assign b_o          = ptr[0];
  assign x_o          = ptr[1];
  assign pcl_o        = tbl_swap ? acc : pc_i[DW-1:0];
  assign dmem_req_o   = (state == ST_DRD) || (state == ST_DWR);
  assign dmem_we_o    = (state == ST_DWR);
  assign dmem_addr_o  = ptr[cur.sel];
  assign dmem_wdata_o = wbuf_q;
  assign pmem_req_o   = (state == ST_TISS);
  assign pmem_addr_o  = {pc_i[PCW-1 -: PGW], acc};
endmodule

// File: rtl/dptr_tbl_unit_chk.sv
module dptr_tbl_unit_chk #(
  parameter int unsigned DW  = 8,
  parameter int unsigned PCW = 15
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cmd_valid_i,
  input logic [2:0]     cmd_op_i,
  input logic [DW-1:0]  cmd_imm_i,
  input logic [PCW-1:0] pc_i,
  input logic           busy_o,
  input logic [DW-1:0]  acc_o,
  input logic [DW-1:0]  b_o,
  input logic [DW-1:0]  x_o,
  input logic [DW-1:0]  pcl_o,
  input logic           dmem_req_o,
  input logic           dmem_we_o,
  input logic [DW-1:0]  dmem_addr_o,
  input logic           dmem_rvalid_i,
  input logic           pmem_req_o,
  input logic [PCW-1:0] pmem_addr_o
);
  localparam int unsigned NIB = DW / 2;

  AST_LDA_IMM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i && cmd_op_i == 3'd1) |=> (acc_o == $past(cmd_imm_i))); // R2

  AST_B_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i && cmd_op_i == 3'd2)
      |=> (b_o == {{(DW-NIB){1'b0}}, $past(cmd_imm_i[NIB-1:0])})); // R3

  AST_DRD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_req_o && !dmem_we_o && !dmem_rvalid_i)
      |=> (dmem_req_o && !dmem_we_o && $stable(dmem_addr_o))); // R4

  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_req_o && dmem_we_o) |=> !dmem_we_o); // R6

  AST_PMEM_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmem_req_o |=> (!pmem_req_o && busy_o)); // R8

  AST_PMEM_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmem_req_o |-> (pmem_addr_o[PCW-1:DW] == pc_i[PCW-1:DW] && pcl_o == pmem_addr_o[DW-1:0])); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!dmem_req_o && !pmem_req_o)); // R10

  AST_PTR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !dmem_req_o) |=> ($stable(b_o) && $stable(x_o))); // R10
endmodule

bind dptr_tbl_unit dptr_tbl_unit_chk #(.DW(DW), .PCW(PCW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_valid_i   (cmd_valid_i),
  .cmd_op_i      (cmd_op_i),
  .cmd_imm_i     (cmd_imm_i),
  .pc_i          (pc_i),
  .busy_o        (busy_o),
  .acc_o         (acc_o),
  .b_o           (b_o),
  .x_o           (x_o),
  .pcl_o         (pcl_o),
  .dmem_req_o    (dmem_req_o),
  .dmem_we_o     (dmem_we_o),
  .dmem_addr_o   (dmem_addr_o),
  .dmem_rvalid_i (dmem_rvalid_i),
  .pmem_req_o    (pmem_req_o),
  .pmem_addr_o   (pmem_addr_o)
);

// File: tb/dptr_tbl_unit_tb.sv
`timescale 1ns/1ps
module dptr_tbl_unit_tb;
  localparam int DW  = 8;
  localparam int PCW = 15;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cmd_valid = 1'b0;
  logic [2:0]     cmd_op = '0;
  logic           cmd_sel = 1'b0;
  logic [1:0]     cmd_step = '0;
  logic [DW-1:0]  cmd_imm = '0;
  logic [PCW-1:0] pc = '0;
  logic           busy;
  logic [DW-1:0]  acc, b, x, pcl;
  logic           dreq, dwe;
  logic [DW-1:0]  daddr, dwdata;
  logic           drvalid = 1'b0;
  logic [DW-1:0]  drdata = '0;
  logic           preq;
  logic [PCW-1:0] paddr;
  logic           prvalid = 1'b0;
  logic [DW-1:0]  prdata = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] mem [256];
  logic [7:0] m_a, m_b, m_x;

  always #2 clk = ~clk;

  dptr_tbl_unit #(.DW(DW), .PCW(PCW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_sel_i(cmd_sel), .cmd_step_i(cmd_step), .cmd_imm_i(cmd_imm), .pc_i(pc),
    .busy_o(busy), .acc_o(acc), .b_o(b), .x_o(x), .pcl_o(pcl),
    .dmem_req_o(dreq), .dmem_we_o(dwe), .dmem_addr_o(daddr), .dmem_wdata_o(dwdata),
    .dmem_rvalid_i(drvalid), .dmem_rdata_i(drdata),
    .pmem_req_o(preq), .pmem_addr_o(paddr), .pmem_rvalid_i(prvalid), .pmem_rdata_i(prdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input int op, input bit sel, input int step, input logic [7:0] imm);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_sel = sel; cmd_step = 2'(step); cmd_imm = imm;
    tick();
    cmd_valid = 1'b0;
  endtask

  function automatic logic [7:0] stepped(input logic [7:0] p, input int step);
    if (step == 1) return p + 8'd1;
    if (step == 2) return p - 8'd1;
    return p;
  endfunction

  function automatic logic [7:0] rom(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  task automatic ld_a(input logic [7:0] v);
    send(1, 1'b0, 0, v);
    m_a = v;
    chk(acc == v, "R2 acc imm", acc, v);
    chk(!busy, "R2 busy", busy, 0);
  endtask

  task automatic ld_x(input logic [7:0] v);
    send(3, 1'b0, 0, v);
    m_x = v;
    chk(x == v, "R2 x imm", x, v);
  endtask

  task automatic ld_b(input logic [7:0] v);
    send(2, 1'b0, 0, v);
    m_b = {4'h0, v[3:0]};
    chk(b == m_b, "R3 b short", b, m_b);
  endtask

  task automatic do_load(input bit sel, input int step, input int lat);
    logic [7:0] p;
    p = sel ? m_x : m_b;
    send(4, sel, step, 8'h00);
    chk(dreq && !dwe && daddr == p, "R4 read addr", daddr, p);
    for (int i = 0; i < lat; i++) begin
      tick();
      chk(dreq && !dwe && daddr == p, "R4 hold", daddr, p);
    end
    drvalid = 1'b1; drdata = mem[p];
    tick();
    drvalid = 1'b0;
    m_a = mem[p];
    if (sel) m_x = stepped(p, step); else m_b = stepped(p, step);
    chk(acc == m_a, "R4 acc load", acc, m_a);
    chk((sel ? x : b) == stepped(p, step), "R5 step load", sel ? x : b, stepped(p, step));
    chk(!busy && !dreq, "R10 idle", busy, 0);
  endtask

  task automatic do_store(input bit sel, input int step);
    logic [7:0] p;
    p = sel ? m_x : m_b;
    send(5, sel, step, 8'h00);
    chk(dreq && dwe && daddr == p, "R6 write addr", daddr, p);
    chk(dwdata == m_a, "R6 write data", dwdata, m_a);
    mem[p] = m_a;
    tick();
    chk(!dreq && !busy, "R6 single write", dreq, 0);
    if (sel) m_x = stepped(p, step); else m_b = stepped(p, step);
    chk((sel ? x : b) == stepped(p, step), "R5 step store", sel ? x : b, stepped(p, step));
  endtask

  task automatic do_xch(input bit sel, input int step, input int lat);
    logic [7:0] p, old_a, old_m;
    p = sel ? m_x : m_b;
    old_a = m_a; old_m = mem[p];
    send(6, sel, step, 8'h00);
    // R10: a competing command held during the whole sequence
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_imm = 8'hEE;
    chk(dreq && !dwe && daddr == p, "R7 read addr", daddr, p);
    for (int i = 0; i < lat; i++) tick();
    drvalid = 1'b1; drdata = old_m;
    tick();
    drvalid = 1'b0;
    chk(dreq && dwe && daddr == p, "R7 write addr pre-step", daddr, p);
    chk(dwdata == old_a, "R7 write old A", dwdata, old_a);
    chk(acc == old_m, "R7 acc gets byte", acc, old_m);
    mem[p] = old_a;
    tick();
    cmd_valid = 1'b0;
    m_a = old_m;
    chk(acc == old_m, "R10 held cmd ignored", acc, old_m);
    if (sel) m_x = stepped(p, step); else m_b = stepped(p, step);
    chk((sel ? x : b) == stepped(p, step), "R5 step xch", sel ? x : b, stepped(p, step));
    chk(!busy, "R7 done", busy, 0);
  endtask

  task automatic do_tbl(input logic [14:0] pcv, input int lat);
    logic [14:0] ea;
    logic [7:0]  a0;
    pc = pcv; a0 = m_a; ea = {pcv[14:8], a0};
    send(7, 1'b0, 0, 8'h00);
    chk(preq && paddr == ea, "R8 pmem addr", paddr, ea);
    chk(pcl == a0 && busy, "R8 pcl swapped", pcl, a0);
    tick();
    chk(!preq && pcl == a0, "R8 one-cycle req", preq, 0);
    for (int i = 0; i < lat; i++) begin
      tick();
      chk(pcl == a0 && busy, "R8 pcl during wait", pcl, a0);
    end
    prvalid = 1'b1; prdata = rom(ea);
    tick();
    prvalid = 1'b0;
    chk(pcl == pcv[7:0] && busy, "R9 pcl restored", pcl, pcv[7:0]);
    tick();
    m_a = rom(ea);
    chk(acc == m_a, "R9 acc table byte", acc, m_a);
    chk(!busy && pcl == pcv[7:0], "R9 done", busy, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R1..all act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    m_a = 0; m_b = 0; m_x = 0;
    repeat (3) @(negedge clk);
    chk(acc == 0 && b == 0 && x == 0, "R1 regs in reset", acc, 0);
    chk(!busy && !dreq && !preq, "R1 quiet in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(acc == 0 && b == 0 && x == 0 && !busy, "R1 after release", {acc, b, x}, 0);

    for (int v = 0; v < 256; v++) ld_b(8'(v));

    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 3; l++) begin
        for (int sel = 0; sel < 2; sel++) begin
          if (sel == 1) ld_x((s == 1) ? 8'hFF : 8'(8'h10 * l + s));
          else          ld_b((s == 2) ? 8'h00 : 8'(9 + l));
          do_load(sel[0], s, l);
          ld_a(8'(8'hA0 + s + l));
          do_store(sel[0], s);
          do_xch(sel[0], s, l);
        end
      end
    end

    // wrap on B through decrement from 00
    ld_b(8'h00);
    do_load(1'b0, 2, 0);
    chk(b == 8'hFF, "R5 wrap dec", b, 8'hFF);
    ld_x(8'hFF);
    do_store(1'b1, 1);
    chk(x == 8'h00, "R5 wrap inc", x, 8'h00);

    for (int a = 0; a < 256; a += 17) begin
      ld_a(8'(a));
      do_tbl(15'(a * 389 + 77), a % 4);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule